// File: doc/BRIEF.md
# Phase Comparator with Output Test Modes and Lock Detection

This block is the digital heart of a frequency-synthesis loop. It divides a crystal-derived tick stream down to a reference rate, then compares each reference event against the event stream from the loop's feedback divider. A tri-state phase/frequency detector turns that comparison into two enables, one for the source side and one for the sink side of an external charge pump. A third line picks the pump current. After every reference event the block also adds a fixed-length push on the source enable, which keeps the analog pump working in its linear region near lock.

A small configuration register is written through a load strobe. It selects the reference ratio, the output-stage mode, the length of the offset push and the pump current. Three of the output modes are test modes: both sources off, source forced on, and sink forced on. A lock monitor measures the width of each detector pulse. It raises its flag as soon as a pulse grows too wide. It drops the flag again only once a complete reference period has passed with no violation.

All inputs are synchronous to `clk`. `ref_tick` and `fb_edge` are single-cycle strobes from upstream logic. The offset lengths and the lock tolerance are given in `clk` cycles.

Top module: `phase_cmp_lockdet`

## Requirements
- R1: A reference event fires on every DIV_LO-th `ref_tick` when the ratio bit is 0, and on every DIV_HI-th when it is 1. When FIXED_HI is set, the ratio is DIV_HI whatever the bit holds. `ref_strobe` pulses for one cycle, one cycle after each reference event.
- R2: If a feedback edge arrives before the reference event, `pump_up` is high from the cycle after the feedback edge until the reference event clears it. Its width equals the lead in cycles.
- R3: If a feedback edge arrives after the reference event, `pump_dn` is high from the cycle after the reference event until the feedback edge clears it. Its width equals the lag in cycles.
- R4: When a feedback edge and a reference event fall in the same cycle, neither detector pulse is produced.
- R5: After each reference event, `pump_up` is also driven for OFS_SHORT cycles when the long-offset bit is 0, and for OFS_LONG cycles when it is 1.
- R6: The 2-bit mode field selects the output stage. 00 is normal detector output. 01 drives both enables low (high impedance). 10 holds `pump_up` high and `pump_dn` low. 11 holds `pump_dn` high and `pump_up` low.
- R7: `pump_low` follows the current-select bit. 1 requests the low pump current and 0 the high current.
- R8: When a detector pulse stays high for more than LOCK_TOL cycles, `unlocked` rises in the next cycle, on either the up side or the down side.
- R9: Detector pulses of LOCK_TOL cycles or fewer never raise `unlocked`.
- R10: `unlocked` falls only at a reference event that closes a full reference period in which no violation occurred. The period in which the violation happened does not count.
- R11: After reset, both enables are low, `unlocked` is high, `pump_low` is 0, and the ratio is DIV_LO (all configuration bits 0).
- R12: The configuration inputs are captured only in a cycle where `cfg_load` is high. Changing them at any other time has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe per crystal period |
| fb_edge | input | 1 | One-cycle strobe per feedback divider output edge |
| cfg_load | input | 1 | Capture the configuration inputs |
| cfg_ratio_hi | input | 1 | Reference ratio select: 0 = DIV_LO, 1 = DIV_HI |
| cfg_mode | input | 2 | Output stage mode (see R6) |
| cfg_long_ofs | input | 1 | Offset length select: 0 = short, 1 = long |
| cfg_low_cur | input | 1 | Pump current select: 1 = low |
| pump_up | output | 1 | Source enable for the charge pump |
| pump_dn | output | 1 | Sink enable for the charge pump |
| pump_low | output | 1 | Low-current select for the charge pump |
| ref_strobe | output | 1 | Divided reference strobe, one cycle late |
| unlocked | output | 1 | High while the loop is out of lock |

## Verification
A stuck or mis-cleared detector flip-flop shows on `pump_up` or `pump_dn` within one reference period. It also pushes the pulse count of that period away from lead/lag plus twice the offset length, which is the quantity the vector table checks. A wrong reference count shifts the `ref_strobe` spacing on its very next period. A wrong lock state shows up in one of two ways. Either the flag rise is off by a cycle from the one that follows the (LOCK_TOL+1)-th pulse cycle, or the flag falls one period too early or too late after a violation.

// File: rtl/phase_cmp_lockdet.sv
module phase_cmp_lockdet #(
  parameter int DIV_LO    = 512,
  parameter int DIV_HI    = 1024,
  parameter bit FIXED_HI  = 1'b0,
  parameter int OFS_SHORT = 4,
  parameter int OFS_LONG  = 7,
  parameter int LOCK_TOL  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       fb_edge,
  input  logic       cfg_load,
  input  logic       cfg_ratio_hi,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_long_ofs,
  input  logic       cfg_low_cur,
  output logic       pump_up,
  output logic       pump_dn,
  output logic       pump_low,
  output logic       ref_strobe,
  output logic       unlocked
);
  localparam int CW = $clog2(DIV_HI);
  localparam int OW = $clog2(OFS_LONG + 1);
  localparam int WW = $clog2(LOCK_TOL + 1);
  localparam logic [1:0] M_NORM = 2'b00, M_HIZ = 2'b01, M_UP = 2'b10, M_DN = 2'b11;

  logic          ratio_q, long_q;
  logic [1:0]    mode_q;
  logic [CW-1:0] div_cnt;
  logic [CW:0]   ratio_m1;
  logic          ref_evt;
  logic          up_ff, dn_ff, up_set, dn_set;
  logic [OW-1:0] ofs_cnt, ofs_len;
  logic          ofs_on;
  logic [WW-1:0] wid_cnt;
  logic          viol, bad_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ratio_q  <= 1'b0;
      mode_q   <= M_NORM;
      long_q   <= 1'b0;
      pump_low <= 1'b0;
    end else if (cfg_load) begin
      ratio_q  <= cfg_ratio_hi;
      mode_q   <= cfg_mode;
      long_q   <= cfg_long_ofs;
      pump_low <= cfg_low_cur;
    end

  assign ratio_m1 = (FIXED_HI || ratio_q) ? (CW+1)'(DIV_HI - 1) : (CW+1)'(DIV_LO - 1);
  assign ref_evt  = ref_tick && ({1'b0, div_cnt} >= ratio_m1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_cnt    <= '0;
      ref_strobe <= 1'b0;
    end else begin
      ref_strobe <= ref_evt;
      if (ref_tick) div_cnt <= ref_evt ? '0 : div_cnt + 1'b1;
    end

  assign up_set = up_ff | fb_edge;
  assign dn_set = dn_ff | ref_evt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      up_ff <= 1'b0;
      dn_ff <= 1'b0;
    end else if (up_set && dn_set) begin
      up_ff <= 1'b0;
      dn_ff <= 1'b0;
    end else begin
      up_ff <= up_set;
      dn_ff <= dn_set;
    end

  assign ofs_len = long_q ? OW'(OFS_LONG) : OW'(OFS_SHORT);
  assign ofs_on  = ofs_cnt < ofs_len;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       ofs_cnt <= OW'(OFS_LONG);
    else if (ref_evt)                 ofs_cnt <= '0;
    else if (ofs_cnt < OW'(OFS_LONG)) ofs_cnt <= ofs_cnt + 1'b1;

  assign viol = (up_ff || dn_ff) && (wid_cnt == WW'(LOCK_TOL));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                         wid_cnt <= '0;
    else if (!(up_ff || dn_ff))         wid_cnt <= '0;
    else if (wid_cnt != WW'(LOCK_TOL))  wid_cnt <= wid_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      unlocked <= 1'b1;
      bad_q    <= 1'b1;
    end else begin
      if (viol)                  unlocked <= 1'b1;
      else if (ref_evt && !bad_q) unlocked <= 1'b0;
      if (ref_evt)   bad_q <= viol;
      else if (viol) bad_q <= 1'b1;
    end

  always_comb
    case (mode_q)
      M_NORM:  begin pump_up = up_ff | ofs_on; pump_dn = dn_ff; end
      M_HIZ:   begin pump_up = 1'b0;           pump_dn = 1'b0;  end
      M_UP:    begin pump_up = 1'b1;           pump_dn = 1'b0;  end
      default: begin pump_up = 1'b0;           pump_dn = 1'b1;  end
    endcase

  a_r4_pfd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_ff && dn_ff));
  a_r1_div_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ref_evt |=> (div_cnt == '0) && ref_strobe);
  a_r5_offset_start: assert property (@(posedge clk) disable iff (!rst_n)
    ref_evt |=> ofs_on);
  a_r8_unlock_next: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> unlocked);
  a_r10_relock_at_ref: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unlocked) |-> $past(ref_evt) && !$past(viol));
endmodule

// File: tb/phase_cmp_lockdet_tb.sv
module phase_cmp_lockdet_tb;
  localparam int CLK_PERIOD = 10;
  localparam int R   = 8;
  localparam int RH  = 16;
  localparam int LS  = 2;
  localparam int LL  = 3;
  localparam int TOL = 3;
  localparam int NV  = 12;
  localparam int V_MODE [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 3, 0};
  localparam int V_LONG [NV] = '{0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0};
  localparam int V_S    [NV] = '{0, -2, -5, 1, 6, 0, -3, 2, -3, 2, -2, 7};
  localparam int V_UP   [NV] = '{4, 6, 9, 4, 4, 6, 9, 6, 0, 16, 0, 4};
  localparam int V_DN   [NV] = '{0, 0, 0, 1, 6, 0, 0, 2, 0, 0, 16, 7};

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_tick = 1'b1, fb_edge = 1'b0, cfg_load = 1'b0;
  logic cfg_ratio_hi = 1'b0, cfg_long_ofs = 1'b0, cfg_low_cur = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic pump_up, pump_dn, pump_low, ref_strobe, unlocked;
  logic fx_up, fx_dn, fx_low, fx_strobe, fx_unl;

  int checks = 0, errors = 0;
  int unl_tr [2*R];
  logic [1:0] nxt_mode;
  logic nxt_long, nxt_load, nxt_low;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_cmp_lockdet #(.DIV_LO(R), .DIV_HI(RH), .FIXED_HI(1'b0), .OFS_SHORT(LS),
    .OFS_LONG(LL), .LOCK_TOL(TOL)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .fb_edge(fb_edge), .cfg_load(cfg_load),
    .cfg_ratio_hi(cfg_ratio_hi), .cfg_mode(cfg_mode), .cfg_long_ofs(cfg_long_ofs),
    .cfg_low_cur(cfg_low_cur), .pump_up(pump_up), .pump_dn(pump_dn), .pump_low(pump_low),
    .ref_strobe(ref_strobe), .unlocked(unlocked));

  phase_cmp_lockdet #(.DIV_LO(R), .DIV_HI(RH), .FIXED_HI(1'b1), .OFS_SHORT(LS),
    .OFS_LONG(LL), .LOCK_TOL(TOL)) u_fix (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .fb_edge(fb_edge), .cfg_load(cfg_load),
    .cfg_ratio_hi(cfg_ratio_hi), .cfg_mode(cfg_mode), .cfg_long_ofs(cfg_long_ofs),
    .cfg_low_cur(cfg_low_cur), .pump_up(fx_up), .pump_dn(fx_dn), .pump_low(fx_low),
    .ref_strobe(fx_strobe), .unlocked(fx_unl));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic spacing(input bit fix, output int n);
    while (!(fix ? fx_strobe : ref_strobe)) @(negedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(fix ? fx_strobe : ref_strobe));
  endtask

  // Entry: at the negedge just after a reference edge A with clean detector state.
  task automatic run_vec(input int s, output int up_c, output int dn_c);
    up_c = 0;
    dn_c = 0;
    for (int k = 0; k < 2*R; k++) begin
      if (k > 0) @(negedge clk);
      up_c += int'(pump_up);
      dn_c += int'(pump_dn);
      unl_tr[k] = int'(unlocked);
      fb_edge = ((k + 1) == R + s) || ((k + 1) == 2*R);
      if (k == 2*R-1) begin
        cfg_mode = nxt_mode;
        cfg_long_ofs = nxt_long;
        cfg_low_cur = nxt_low;
        cfg_load = nxt_load;
      end
    end
    @(negedge clk);
    fb_edge = 1'b0;
    cfg_load = 1'b0;
    chk("R1 strobe after period", int'(ref_strobe), 1);
  endtask

  task automatic set_nxt(input int m, input int l, input bit ld, input bit lc);
    nxt_mode = 2'(m);
    nxt_long = l[0];
    nxt_load = ld;
    nxt_low = lc;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, up_c, dn_c, any;
    repeat (3) @(negedge clk);
    chk("R11 pump_up reset", int'(pump_up), 0);
    chk("R11 pump_dn reset", int'(pump_dn), 0);
    chk("R11 unlocked reset", int'(unlocked), 1);
    chk("R11 pump_low reset", int'(pump_low), 0);
    chk("R11 strobe reset", int'(ref_strobe), 0);
    rst_n = 1'b1;

    spacing(1'b0, n);
    chk("R11 R1 default ratio", n, R);
    spacing(1'b1, n);
    chk("R1 fixed-high ratio", n, RH);

    // align: clear pending pulse, then make the next reference edge coincide
    while (!ref_strobe) @(negedge clk);
    fb_edge = 1'b1;
    @(negedge clk);
    fb_edge = 1'b0;
    repeat (R-2) @(negedge clk);
    fb_edge = 1'b1;
    cfg_mode = 2'(V_MODE[0]);
    cfg_long_ofs = V_LONG[0][0];
    cfg_load = 1'b1;
    @(negedge clk);
    fb_edge = 1'b0;
    cfg_load = 1'b0;

    for (int i = 0; i < NV; i++) begin
      string tag;
      if (i < NV-1) set_nxt(V_MODE[i+1], V_LONG[i+1], 1'b1, 1'b0);
      else          set_nxt(0, 0, 1'b1, 1'b0);
      run_vec(V_S[i], up_c, dn_c);
      tag = (V_MODE[i] != 0) ? "R6" : (V_LONG[i] != 0) ? "R5" :
            (V_S[i] < 0) ? "R2" : (V_S[i] > 0) ? "R3" : "R4";
      chk($sformatf("%s vec%0d up", tag, i), up_c, V_UP[i]);
      chk($sformatf("%s vec%0d dn", tag, i), dn_c, V_DN[i]);
    end

    set_nxt(0, 0, 1'b1, 1'b0);
    repeat (3) run_vec(0, up_c, dn_c);
    chk("R10 locked after clean periods", unl_tr[0] + unl_tr[2*R-1], 0);

    run_vec(3, up_c, dn_c);
    any = 0;
    for (int k = 0; k < 2*R; k++) any += unl_tr[k];
    chk("R9 width at tolerance keeps lock", any, 0);

    run_vec(4, up_c, dn_c);
    chk("R8 lag unlock not early", unl_tr[11], 0);
    chk("R8 lag unlock immediate", unl_tr[12], 1);

    run_vec(0, up_c, dn_c);
    chk("R10 still unlocked before full period", unl_tr[7], 1);
    chk("R10 relock after full period", unl_tr[8], 0);

    run_vec(-4, up_c, dn_c);
    chk("R8 lead unlock not early", unl_tr[7], 0);
    chk("R8 lead unlock immediate", unl_tr[8], 1);

    set_nxt(1, 1, 1'b0, 1'b1);
    run_vec(0, up_c, dn_c);
    set_nxt(0, 0, 1'b1, 1'b1);
    run_vec(0, up_c, dn_c);
    chk("R12 unloaded cfg ignored up", up_c, 2*LS);
    chk("R12 unloaded cfg ignored dn", dn_c, 0);
    chk("R7 low current select", int'(pump_low), 1);
    chk("R7 pumps unaffected by current select", int'(pump_dn), 0);

    cfg_ratio_hi = 1'b1;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    spacing(1'b0, n);
    chk("R1 high ratio", n, RH);
    spacing(1'b1, n);
    chk("R1 fixed-high ratio after load", n, RH);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule